// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a double-data-rate SDRAM interface. It takes the memory from power-on to the all-banks-idle state. A single start pulse launches a fixed command program. The block first holds the clock enable low while the supply and clock settle, then raises it. It then closes every bank, programs the extended mode word, programs the base mode word with a DLL reset, waits for the DLL to lock, runs a series of auto-refreshes, and rewrites the base mode word without the reset. After that it reports completion. Between commands it drives only NOP, and while the clock enable is low it drives deselect.

The burst length, CAS latency, output drive strength and DLL enable are captured when the start pulse is accepted. They are packed into the two mode words, and the bank address selects which word is written. All waits are counters whose limits come from picosecond timing parameters divided by the clock period and rounded up. The DLL lock wait is a plain cycle count. A start pulse received after completion runs the whole program again.

Top module: `ddr_init_seq`

## Requirements
- R1: During and after reset, with no start pulse, the block drives clock enable low, chip select high (deselect), command-valid low and done low.
- R2: A start accepted at a clock edge begins a window of N_PWR = ceil(T_POWERUP_PS/CLK_PS) cycles (minimum 1) with clock enable low and deselect. This is followed by one cycle with clock enable high and a NOP. Clock enable then stays high until the next accepted start.
- R3: Pin encodings (chip select, RAS, CAS, WE, all active low) are: NOP = 0,1,1,1; precharge-all = 0,0,1,0 with address bit 10 high; mode write = 0,0,0,0; auto-refresh = 0,0,0,1. Command-valid is high exactly in the cycles that carry a precharge-all, mode write or auto-refresh.
- R4: The commands come in this order: one precharge-all, the extended mode write, the base mode write with DLL reset, N_REF auto-refreshes, and the final base mode write.
- R5: The extended mode write uses bank address 2'b01. Address bit 0 is the inverse of the DLL enable input (1 = DLL off). Address bit 1 is the drive strength (0 normal, 1 weak). All other address bits are 0.
- R6: Base mode writes use bank address 2'b00. Address bits 2:0 are the burst code (3'b001 = 2, 3'b010 = 4, 3'b011 = 8). A burst input of 2'b00 is coerced to 3'b001. Bit 3 is 0. Bits 6:4 are 3'b010 for CAS latency 2 (latency input 0) and 3'b110 for 2.5 (latency input 1). Bit 8 is 1 on the first base write and 0 on the final one. All other bits are 0.
- R7: The extended mode write follows the precharge-all by G_RP = max(2, ceil(T_RP_PS/CLK_PS)) cycles. The second mode write follows the first by G_MRD = max(2, ceil(T_MRD_PS/CLK_PS)) cycles.
- R8: The first auto-refresh follows the DLL-reset mode write by G_LOCK = max(2, DLL_LOCK_CYC, G_MRD) cycles.
- R9: Consecutive auto-refreshes, and the last auto-refresh and the final mode write, are G_RFC = max(2, ceil(T_RFC_PS/CLK_PS)) cycles apart.
- R10: Done rises G_MRD cycles after the final mode write. It then holds with NOPs and no command-valid until a new start.
- R11: Configuration inputs are sampled only when a start is accepted. Changes while the program runs do not alter the mode words.
- R12: A start pulse while the program is running has no effect on the command stream.
- R13: A start while done is high restarts the program, and done drops in the first window cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle or done |
| cfg_bl_i | input | 2 | Burst length code (01=2, 10=4, 11=8, 00 coerced to 2) |
| cfg_cl_i | input | 1 | CAS latency select (0 = 2, 1 = 2.5) |
| cfg_ds_i | input | 1 | Drive strength (0 normal, 1 weak) |
| cfg_dll_en_i | input | 1 | DLL enable (1 = on) |
| mem_cke_o | output | 1 | Clock enable to memory |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_ras_n_o | output | 1 | Row strobe, active low |
| mem_cas_n_o | output | 1 | Column strobe, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_ba_o | output | 2 | Bank address |
| mem_addr_o | output | ADDR_W | Address bus |
| cmd_vld_o | output | 1 | High in cycles carrying a real command |
| done_o | output | 1 | Initialization complete |

## Verification
The hardest cases to reach from the ports are a start pulse and a configuration change arriving in the middle of the long DLL lock wait. Both would have to leave no trace in the later mode words. The bench reaches them in every run. It flips every configuration input to its opposite just after the accepted start, and it pulses start again inside the lock window. It then compares the full pin tuple in every cycle against a schedule computed from the timing parameters. The configuration sweep covers all burst codes, including the coerced one, both latencies, both drive strengths and both DLL settings. The runs go back to back from the done state, so each run also exercises the restart path.

// File: rtl/ddr_init_pkg.sv
`timescale 1ns/1ps
package ddr_init_pkg;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_PALL,
        CMD_MODE,
        CMD_AREF
    } mem_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR,
        ST_CKEUP,
        ST_PALL,
        ST_EMODE,
        ST_MODE_RST,
        ST_AREF,
        ST_MODE_FIN,
        ST_GAP,
        ST_DONE
    } seq_st_e;

    // cycles needed to cover a picosecond interval, rounded up
    function automatic int unsigned ps_to_cyc(int unsigned ps, int unsigned clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

    // spacing between two command issues; the gap state needs at least 2
    function automatic int unsigned gap_min2(int unsigned c);
        return (c < 2) ? 2 : c;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_init_mode_enc.sv
`timescale 1ns/1ps
module ddr_init_mode_enc #(
    parameter int unsigned ADDR_W = 13
) (
    input  logic [1:0]        bl_i,
    input  logic              cl_half_i,
    input  logic              weak_i,
    input  logic              dll_en_i,
    input  logic              dll_rst_i,
    output logic [ADDR_W-1:0] base_word_o,
    output logic [ADDR_W-1:0] ext_word_o
);
    logic [1:0] bl_code;

    always_comb begin
        bl_code = (bl_i == 2'b00) ? 2'b01 : bl_i;

        base_word_o      = '0;
        base_word_o[2:0] = {1'b0, bl_code};
        base_word_o[3]   = 1'b0;
        base_word_o[6:4] = cl_half_i ? 3'b110 : 3'b010;
        base_word_o[8]   = dll_rst_i;

        ext_word_o       = '0;
        ext_word_o[0]    = ~dll_en_i;
        ext_word_o[1]    = weak_i;
    end
endmodule

// File: rtl/ddr_init_cmd_drv.sv
`timescale 1ns/1ps
module ddr_init_cmd_drv
    import ddr_init_pkg::*;
(
    input  mem_cmd_e cmd_i,
    output logic     cs_n_o,
    output logic     ras_n_o,
    output logic     cas_n_o,
    output logic     we_n_o,
    output logic     vld_o
);
    always_comb begin
        cs_n_o  = 1'b0;
        ras_n_o = 1'b1;
        cas_n_o = 1'b1;
        we_n_o  = 1'b1;
        vld_o   = 1'b0;
        case (cmd_i)
            CMD_DESEL: cs_n_o = 1'b1;
            CMD_PALL: begin
                ras_n_o = 1'b0;
                we_n_o  = 1'b0;
                vld_o   = 1'b1;
            end
            CMD_MODE: begin
                ras_n_o = 1'b0;
                cas_n_o = 1'b0;
                we_n_o  = 1'b0;
                vld_o   = 1'b1;
            end
            CMD_AREF: begin
                ras_n_o = 1'b0;
                cas_n_o = 1'b0;
                vld_o   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr_init_seq.sv
`timescale 1ns/1ps
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned CLK_PS       = 4000,
    parameter int unsigned T_POWERUP_PS = 200_000_000,
    parameter int unsigned T_RP_PS      = 18000,
    parameter int unsigned T_MRD_PS     = 12000,
    parameter int unsigned T_RFC_PS     = 72000,
    parameter int unsigned DLL_LOCK_CYC = 200,
    parameter int unsigned N_REF        = 2,
    parameter int unsigned ADDR_W       = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        cfg_bl_i,
    input  logic              cfg_cl_i,
    input  logic              cfg_ds_i,
    input  logic              cfg_dll_en_i,
    output logic              mem_cke_o,
    output logic              mem_cs_n_o,
    output logic              mem_ras_n_o,
    output logic              mem_cas_n_o,
    output logic              mem_we_n_o,
    output logic [1:0]        mem_ba_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              cmd_vld_o,
    output logic              done_o
);
    localparam int unsigned N_PWR   = umax(1, ps_to_cyc(T_POWERUP_PS, CLK_PS));
    localparam int unsigned G_RP    = gap_min2(ps_to_cyc(T_RP_PS, CLK_PS));
    localparam int unsigned G_MRD   = gap_min2(ps_to_cyc(T_MRD_PS, CLK_PS));
    localparam int unsigned G_RFC   = gap_min2(ps_to_cyc(T_RFC_PS, CLK_PS));
    localparam int unsigned G_LOCK  = gap_min2(umax(DLL_LOCK_CYC, G_MRD));
    localparam int unsigned MAX_CNT = umax(umax(N_PWR, G_LOCK), umax(G_RFC, umax(G_RP, G_MRD)));
    localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
    localparam int unsigned REF_W   = $clog2(N_REF + 1);

    typedef struct packed {
        seq_st_e          st;
        seq_st_e          nxt;
        logic [CNT_W-1:0] cnt;
        logic [REF_W-1:0] refs;
        logic [1:0]       bl;
        logic             cl;
        logic             ds;
        logic             dll;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    s_d.st   = ST_PWR;
                    s_d.cnt  = CNT_W'(N_PWR - 1);
                    s_d.refs = '0;
                    s_d.bl   = cfg_bl_i;
                    s_d.cl   = cfg_cl_i;
                    s_d.ds   = cfg_ds_i;
                    s_d.dll  = cfg_dll_en_i;
                end
            end
            ST_PWR: begin
                if (s_q.cnt == '0) s_d.st  = ST_CKEUP;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            ST_CKEUP: s_d.st = ST_PALL;
            ST_PALL: begin
                s_d.st  = ST_GAP;
                s_d.nxt = ST_EMODE;
                s_d.cnt = CNT_W'(G_RP - 2);
            end
            ST_EMODE: begin
                s_d.st  = ST_GAP;
                s_d.nxt = ST_MODE_RST;
                s_d.cnt = CNT_W'(G_MRD - 2);
            end
            ST_MODE_RST: begin
                s_d.st  = ST_GAP;
                s_d.nxt = ST_AREF;
                s_d.cnt = CNT_W'(G_LOCK - 2);
            end
            ST_AREF: begin
                s_d.st   = ST_GAP;
                s_d.cnt  = CNT_W'(G_RFC - 2);
                s_d.refs = s_q.refs + 1'b1;
                s_d.nxt  = (s_q.refs == REF_W'(N_REF - 1)) ? ST_MODE_FIN : ST_AREF;
            end
            ST_MODE_FIN: begin
                s_d.st  = ST_GAP;
                s_d.nxt = ST_DONE;
                s_d.cnt = CNT_W'(G_MRD - 2);
            end
            ST_GAP: begin
                if (s_q.cnt == '0) s_d.st  = s_q.nxt;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, nxt: ST_IDLE, cnt: '0, refs: '0,
                     bl: 2'b01, cl: 1'b0, ds: 1'b0, dll: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    // output decode
    mem_cmd_e          cmd;
    logic [ADDR_W-1:0] base_word, ext_word;

    ddr_init_mode_enc #(.ADDR_W(ADDR_W)) u_enc (
        .bl_i       (s_q.bl),
        .cl_half_i  (s_q.cl),
        .weak_i     (s_q.ds),
        .dll_en_i   (s_q.dll),
        .dll_rst_i  (s_q.st == ST_MODE_RST),
        .base_word_o(base_word),
        .ext_word_o (ext_word)
    );

    always_comb begin
        cmd        = CMD_NOP;
        mem_ba_o   = 2'b00;
        mem_addr_o = '0;
        case (s_q.st)
            ST_IDLE, ST_PWR: cmd = CMD_DESEL;
            ST_PALL: begin
                cmd            = CMD_PALL;
                mem_addr_o[10] = 1'b1;
            end
            ST_EMODE: begin
                cmd        = CMD_MODE;
                mem_ba_o   = 2'b01;
                mem_addr_o = ext_word;
            end
            ST_MODE_RST, ST_MODE_FIN: begin
                cmd        = CMD_MODE;
                mem_addr_o = base_word;
            end
            ST_AREF: cmd = CMD_AREF;
            default: cmd = CMD_NOP;
        endcase
    end

    ddr_init_cmd_drv u_drv (
        .cmd_i  (cmd),
        .cs_n_o (mem_cs_n_o),
        .ras_n_o(mem_ras_n_o),
        .cas_n_o(mem_cas_n_o),
        .we_n_o (mem_we_n_o),
        .vld_o  (cmd_vld_o)
    );

    assign mem_cke_o = (s_q.st != ST_IDLE) && (s_q.st != ST_PWR);
    assign done_o    = (s_q.st == ST_DONE);

endmodule

// File: rtl/ddr_init_seq_chk.sv
`timescale 1ns/1ps
module ddr_init_seq_chk
    import ddr_init_pkg::*;
#(
    parameter int unsigned CLK_PS       = 4000,
    parameter int unsigned T_MRD_PS     = 12000,
    parameter int unsigned T_RFC_PS     = 72000,
    parameter int unsigned DLL_LOCK_CYC = 200,
    parameter int unsigned ADDR_W       = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mem_cke_o,
    input logic              mem_cs_n_o,
    input logic              mem_ras_n_o,
    input logic              mem_cas_n_o,
    input logic              mem_we_n_o,
    input logic [1:0]        mem_ba_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              cmd_vld_o,
    input logic              done_o
);
    localparam int unsigned G_MRD  = gap_min2(ps_to_cyc(T_MRD_PS, CLK_PS));
    localparam int unsigned G_RFC  = gap_min2(ps_to_cyc(T_RFC_PS, CLK_PS));
    localparam int unsigned G_LOCK = gap_min2(umax(DLL_LOCK_CYC, G_MRD));

    logic is_mode, is_ref, is_rst;
    logic [15:0] since_mode, since_ref, since_rst;

    assign is_mode = cmd_vld_o && !mem_ras_n_o && !mem_cas_n_o && !mem_we_n_o;
    assign is_ref  = cmd_vld_o && !mem_ras_n_o && !mem_cas_n_o && mem_we_n_o;
    assign is_rst  = is_mode && (mem_ba_o == 2'b00) && mem_addr_o[8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_mode <= '1;
            since_ref  <= '1;
            since_rst  <= '1;
        end else begin
            since_mode <= is_mode ? 16'd1 : ((since_mode == '1) ? since_mode : since_mode + 16'd1);
            since_ref  <= is_ref  ? 16'd1 : ((since_ref  == '1) ? since_ref  : since_ref  + 16'd1);
            since_rst  <= is_rst  ? 16'd1 : ((since_rst  == '1) ? since_rst  : since_rst  + 16'd1);
        end
    end

    AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> (mem_cke_o && !mem_cs_n_o)); // R3
    AST_CKE_DROP_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cke_o) |-> $past(start_i)); // R2
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cmd_vld_o); // R10
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R10
    AST_MODE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode |-> (32'(since_mode) >= G_MRD)); // R7
    AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (32'(since_ref) >= G_RFC)); // R9
    AST_DLL_LOCK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (32'(since_rst) >= G_LOCK)); // R8
    AST_EXT_WORD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mode && mem_ba_o == 2'b01) |-> (mem_addr_o[ADDR_W-1:2] == '0)); // R5

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
    .CLK_PS      (CLK_PS),
    .T_MRD_PS    (T_MRD_PS),
    .T_RFC_PS    (T_RFC_PS),
    .DLL_LOCK_CYC(DLL_LOCK_CYC),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mem_cke_o  (mem_cke_o),
    .mem_cs_n_o (mem_cs_n_o),
    .mem_ras_n_o(mem_ras_n_o),
    .mem_cas_n_o(mem_cas_n_o),
    .mem_we_n_o (mem_we_n_o),
    .mem_ba_o   (mem_ba_o),
    .mem_addr_o (mem_addr_o),
    .cmd_vld_o  (cmd_vld_o),
    .done_o     (done_o)
);

// File: tb/ddr_init_seq_bench.sv
`timescale 1ns/1ps
module ddr_init_seq_bench;
    localparam int CLK_PS   = 4000;
    localparam int PWR_PS   = 40000;
    localparam int RP_PS    = 15000;
    localparam int MRD_PS   = 8000;
    localparam int RFC_PS   = 70000;
    localparam int LOCK_CYC = 200;
    localparam int NREF     = 2;

    function automatic int cdiv(int a, int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int atleast2(int c);
        return (c < 2) ? 2 : c;
    endfunction

    localparam int NP    = cdiv(PWR_PS, CLK_PS);
    localparam int GRP   = atleast2(cdiv(RP_PS, CLK_PS));
    localparam int GMRD  = atleast2(cdiv(MRD_PS, CLK_PS));
    localparam int GRFC  = atleast2(cdiv(RFC_PS, CLK_PS));
    localparam int GLOCK = atleast2((LOCK_CYC > GMRD) ? LOCK_CYC : GMRD);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  bl = 2'b01;
    logic        cl = 1'b0, ds = 1'b0, dll = 1'b1;
    logic        cke, cs_n, ras_n, cas_n, we_n, vld, done;
    logic [1:0]  ba;
    logic [12:0] addr;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ddr_init_seq #(
        .CLK_PS(CLK_PS), .T_POWERUP_PS(PWR_PS), .T_RP_PS(RP_PS),
        .T_MRD_PS(MRD_PS), .T_RFC_PS(RFC_PS), .DLL_LOCK_CYC(LOCK_CYC),
        .N_REF(NREF), .ADDR_W(13)
    ) u_ddr_init_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .cfg_bl_i(bl), .cfg_cl_i(cl), .cfg_ds_i(ds), .cfg_dll_en_i(dll),
        .mem_cke_o(cke), .mem_cs_n_o(cs_n), .mem_ras_n_o(ras_n),
        .mem_cas_n_o(cas_n), .mem_we_n_o(we_n), .mem_ba_o(ba),
        .mem_addr_o(addr), .cmd_vld_o(vld), .done_o(done)
    );

    // expected schedule, relative to the first power-window cycle
    int tP, tE, tM1, tR0, tM2, tD;
    logic [12:0] exp_base, exp_ext;

    function automatic logic [21:0] pins_now();
        return {cke, cs_n, ras_n, cas_n, we_n, ba, addr, vld, done};
    endfunction

    function automatic logic [21:0] expect_at(int t);
        logic k, c, r, a, w, v, d;
        logic [1:0]  b;
        logic [12:0] ad;
        k = 1'b1; c = 1'b0; r = 1'b1; a = 1'b1; w = 1'b1;
        b = 2'b00; ad = '0; v = 1'b0; d = 1'b0;
        if (t < NP) begin
            k = 1'b0; c = 1'b1;
        end else if (t == tP) begin
            r = 1'b0; w = 1'b0; ad = 13'd1 << 10; v = 1'b1;
        end else if (t == tE) begin
            r = 1'b0; a = 1'b0; w = 1'b0; b = 2'b01; ad = exp_ext; v = 1'b1;
        end else if (t == tM1) begin
            r = 1'b0; a = 1'b0; w = 1'b0; ad = exp_base | 13'h100; v = 1'b1;
        end else if (t >= tR0 && t < tM2 && ((t - tR0) % GRFC) == 0) begin
            r = 1'b0; a = 1'b0; v = 1'b1;
        end else if (t == tM2) begin
            r = 1'b0; a = 1'b0; w = 1'b0; ad = exp_base; v = 1'b1;
        end else if (t >= tD) begin
            d = 1'b1;
        end
        return {k, c, r, a, w, b, ad, v, d};
    endfunction

    function automatic string tag_at(int t);
        if (t == 0)                 return "R13 R2";
        if (t < NP)                 return "R2";
        if (t == NP)                return "R2 R3";
        if (t == tP)                return "R3 R4";
        if (t == tE)                return "R5 R11 R7";
        if (t == tM1)               return "R6 R11 R7";
        if (t > tM1 && t <= tR0)    return "R8 R12";
        if (t > tR0 && t < tM2)     return "R9 R4";
        if (t == tM2)               return "R6 R9 R11";
        if (t >= tD)                return "R10";
        return "R7 R3";
    endfunction

    task automatic check(string tag, logic [21:0] act, logic [21:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic run_one(logic [1:0] b_in, logic c_in, logic d_in, logic l_in, bit first);
        int blc;
        blc      = (b_in == 2'b00) ? 1 : int'(b_in);
        exp_base = 13'(blc + ((c_in ? 6 : 2) << 4));
        exp_ext  = 13'((l_in ? 0 : 1) + (d_in ? 2 : 0));
        tP  = NP + 1;
        tE  = tP + GRP;
        tM1 = tE + GMRD;
        tR0 = tM1 + GLOCK;
        tM2 = tR0 + NREF * GRFC;
        tD  = tM2 + GMRD;

        @(negedge clk);
        if (first) check("R1", {cke, cs_n, vld, done}, 4'b0100);
        else       check("R10 R13", {22'(done)}, 22'd1);
        bl = b_in; cl = c_in; ds = d_in; dll = l_in;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11: inputs moved away from the captured values
        bl = ~b_in; cl = ~c_in; ds = ~d_in; dll = ~l_in;
        for (int t = 0; t <= tD + 3; t++) begin
            check(tag_at(t), pins_now(), expect_at(t));
            if (t == 20) start = 1'b1;  // R12: mid-sequence pulse
            if (t == 21) start = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200_000 * 4);
        fails++;
        checks++;
        $display("FAIL R10 watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit first;
        // R1: reset state
        repeat (4) begin
            @(negedge clk);
            check("R1", {cke, cs_n, vld, done}, 4'b0100);
        end
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1", {cke, cs_n, vld, done}, 4'b0100);
        end
        first = 1'b1;
        for (int ib = 0; ib < 4; ib++)
            for (int ic = 0; ic < 2; ic++)
                for (int id = 0; id < 2; id++)
                    for (int il = 0; il < 2; il++) begin
                        run_one(2'(ib), 1'(ic), 1'(id), 1'(il), first);
                        first = 1'b0;
                    end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule